// File: doc/BRIEF.md
# LCD Row Scanner

This block produces the refresh stream for a passive dot-matrix LCD with 61 segment columns and a common window of 16 lines per chip. A line timer counts divided oscillator ticks and steps a common counter once per line period. The counter wraps after 16 or 32 lines, depending on the duty setting. During each line period a fetch sequencer reads the byte-wide display RAM once for each segment and picks out the bit that belongs to the next line. At the line boundary the assembled row is loaded into the output latch, at the same moment the common selection moves on.

The displayed RAM line equals a start-line offset plus the common index, taken modulo 32, so rewriting the offset scrolls the picture. A reverse setting mirrors the column order across the segments. Two chips can share one panel. The master drives commons 0 to 15 and produces the polarity-reversal signal. The slave drives commons 16 to 31 and takes that polarity signal from the master. Blanking, static all-on drive and a power-save hold act at the outputs and on the timer.

Top module: `lcd_row_scan`

## Requirements
- R1: The row shown for global common n uses RAM line L = (start_line + n) mod 32. Each segment bit is bit L[2:0] of the byte at page L[4:3], where ram_addr = {page[1:0], column[6:0]}.
- R2: With seg_reverse = 0, segment s shows column s. With seg_reverse = 1, it shows column 79 − s, so segment 0 shows column 79.
- R3: The common counter advances once every LINE_TICKS osc_tick pulses. It counts 0..15 when duty_full = 0 and 0..31 when duty_full = 1, then wraps to 0.
- R4: With is_slave = 0, com_sel is one-hot at bit n for counter values n < 16 and zero otherwise. With is_slave = 1, bit n − 16 is set for n ≥ 16, and com_sel is zero for n < 16.
- R5: The master's fr_out toggles exactly when the counter wraps to 0. A slave drives fr_out from fr_in.
- R6: seg_data changes only at a line boundary, in the same clock as the common step, and then holds the row of the new common.
- R7: When disp_on = 0, com_sel and seg_data are all zero whatever the RAM holds.
- R8: When disp_on = 1 and static_on = 1, every bit of seg_data is 1 while the commons keep scanning.
- R9: When disp_on = 0 and static_on = 1 (power save), the counter and fr_out hold. After the display is re-enabled, scanning resumes from the same common.
- R10: In a cycle with host_busy = 1, no scan read is issued. The pending fetch waits and retries on the next free cycle, and the row is still complete at the boundary.
- R11: After reset the counter is 0, the row latch is all zero and fr_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Divided oscillator tick, one clock wide |
| disp_on | input | 1 | 1 = display enabled, 0 = blank |
| static_on | input | 1 | All segments lit; with disp_on = 0 selects power save |
| seg_reverse | input | 1 | 1 = mirrored column-to-segment order |
| duty_full | input | 1 | 1 = 32-line scan, 0 = 16-line scan |
| is_slave | input | 1 | 1 = this chip drives commons 16..31 |
| start_line | input | 5 | RAM line shown on common 0 |
| host_busy | input | 1 | Host owns the RAM port this cycle |
| ram_rd | output | 1 | Scan read strobe |
| ram_addr | output | 9 | {page, column} of the scan read |
| ram_rdata | input | 8 | RAM byte, valid one clock after ram_rd |
| fr_in | input | 1 | Polarity signal from the master (slave use) |
| fr_out | output | 1 | Drive-polarity reversal signal |
| com_sel | output | 16 | One-hot common select |
| seg_data | output | 61 | Latched segment row |

## Verification
The conflict that matters is a host RAM access landing in the same cycle as a scan fetch. The bench raises host_busy on a fixed fraction of cycles (one in three, or two in five) while the fetch sequencer walks the columns. It then checks every row that reaches the latch against a bit-exact expectation computed from the bench's own RAM image. A fetch that is dropped or duplicated during a collision shows up as a wrong bit in that row. Line-period spacing, wrap order and FR toggling are checked in the same runs, so any slip in timing also shows up.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
   // column of the display RAM feeding a given segment output
   function automatic int unsigned seg_to_col(input int unsigned seg,
                                              input int unsigned ncol,
                                              input logic        rev);
      return rev ? (ncol - 1 - seg) : seg;
   endfunction
endpackage

// File: rtl/lcd_line_timer.sv
module lcd_line_timer #(
   parameter int LINE_TICKS = 128,
   parameter int NCOM       = 16,
   parameter int NLINE      = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     osc_tick,
   input  logic                     run,
   input  logic                     duty_full,
   output logic [$clog2(NLINE)-1:0] cnt,
   output logic [$clog2(NLINE)-1:0] cnt_nxt,
   output logic                     line_end,
   output logic                     fr
);
   localparam int LW = $clog2(NLINE);
   localparam int TW = (LINE_TICKS > 1) ? $clog2(LINE_TICKS) : 1;

   logic [TW-1:0] tcnt;
   logic [LW-1:0] last;

   assign last     = duty_full ? LW'(NLINE - 1) : LW'(NCOM - 1);
   assign cnt_nxt  = (cnt >= last) ? '0 : cnt + 1'b1;
   assign line_end = run && osc_tick && (tcnt == TW'(LINE_TICKS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tcnt <= '0;
         cnt  <= '0;
         fr   <= 1'b0;
      end else begin
         if (run && osc_tick) tcnt <= line_end ? '0 : tcnt + 1'b1;
         if (line_end) begin
            cnt <= cnt_nxt;
            if (cnt_nxt == '0) fr <= ~fr;
         end
      end
   end

   AST_DUTY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (line_end && !duty_full) |=> (cnt < LW'(NCOM))); // R3
   AST_STEP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt) |-> $past(line_end)); // R3
   AST_FR_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fr) |-> (cnt == '0)); // R5
   AST_PS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ($stable(cnt) && $stable(fr))); // R9
endmodule

// File: rtl/lcd_row_fetch.sv
module lcd_row_fetch #(
   parameter int NSEG  = 61,
   parameter int NCOL  = 80,
   parameter int NLINE = 32,
   parameter int DW    = 8
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      run,
   input  logic                                      line_end,
   input  logic                                      reverse,
   input  logic [$clog2(NLINE)-1:0]                  start_line,
   input  logic [$clog2(NLINE)-1:0]                  cnt_nxt,
   input  logic                                      host_busy,
   output logic                                      ram_rd,
   output logic [$clog2(NLINE/DW)+$clog2(NCOL)-1:0]  ram_addr,
   input  logic [DW-1:0]                             ram_rdata,
   output logic [NSEG-1:0]                           row
);
   localparam int LW = $clog2(NLINE);
   localparam int BW = $clog2(DW);
   localparam int CW = $clog2(NCOL);
   localparam int FW = $clog2(NSEG + 1);

   logic [LW-1:0]   fline;
   logic [FW-1:0]   fidx;
   logic [FW-1:0]   rd_idx;
   logic            rd_q;
   logic [CW-1:0]   col;
   logic [NSEG-1:0] shadow;

   assign fline    = cnt_nxt + start_line;
   assign col      = CW'(lcd_scan_pkg::seg_to_col(32'(fidx), NCOL, reverse));
   assign ram_rd   = run && !line_end && !host_busy && (fidx < FW'(NSEG));
   assign ram_addr = {fline[LW-1:BW], col};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fidx   <= '0;
         rd_idx <= '0;
         rd_q   <= 1'b0;
         shadow <= '0;
         row    <= '0;
      end else begin
         rd_q   <= ram_rd;
         rd_idx <= fidx;
         if (ram_rd) fidx <= fidx + 1'b1;
         if (rd_q) shadow[rd_idx] <= ram_rdata[fline[BW-1:0]];
         if (line_end) begin
            row  <= shadow;
            fidx <= '0;
         end
      end
   end

   AST_HOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      host_busy |-> !ram_rd); // R10
   AST_FETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (run && host_busy && !line_end) |=> $stable(fidx)); // R10
   AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !line_end |=> $stable(row)); // R6
endmodule

// File: rtl/lcd_com_window.sv
module lcd_com_window #(
   parameter int NCOM  = 16,
   parameter int NLINE = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(NLINE)-1:0] cnt,
   input  logic                     is_slave,
   input  logic                     enable,
   output logic [NCOM-1:0]          com_sel
);
   localparam int LW = $clog2(NLINE);

   logic [LW-1:0] base;
   logic [LW-1:0] rel;
   logic          in_win;

   assign base   = is_slave ? LW'(NCOM) : '0;
   assign rel    = cnt - base;
   assign in_win = (cnt >= base) && (rel < LW'(NCOM));

   for (genvar g = 0; g < NCOM; g++) begin : g_com
      assign com_sel[g] = enable && in_win && (rel == LW'(g));
   end

   AST_MASTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !is_slave && cnt < LW'(NCOM)) |-> ($countones(com_sel) == 1)); // R4
   AST_SLAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (is_slave && cnt < LW'(NCOM)) |-> (com_sel == '0)); // R4
endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan #(
   parameter int NSEG       = 61,
   parameter int NCOL       = 80,
   parameter int NCOM       = 16,
   parameter int NLINE      = 32,
   parameter int DW         = 8,
   parameter int LINE_TICKS = 128
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     osc_tick,
   input  logic                                     disp_on,
   input  logic                                     static_on,
   input  logic                                     seg_reverse,
   input  logic                                     duty_full,
   input  logic                                     is_slave,
   input  logic [$clog2(NLINE)-1:0]                 start_line,
   input  logic                                     host_busy,
   output logic                                     ram_rd,
   output logic [$clog2(NLINE/DW)+$clog2(NCOL)-1:0] ram_addr,
   input  logic [DW-1:0]                            ram_rdata,
   input  logic                                     fr_in,
   output logic                                     fr_out,
   output logic [NCOM-1:0]                          com_sel,
   output logic [NSEG-1:0]                          seg_data
);
   localparam int LW = $clog2(NLINE);

   if (NLINE != 2 * NCOM)          begin : g_bad_win   $error("NLINE must be twice NCOM");        end
   if ((1 << LW) != NLINE)         begin : g_bad_line  $error("NLINE must be a power of two");    end
   if (NSEG > NCOL)                begin : g_bad_seg   $error("NSEG exceeds NCOL");               end
   if (LINE_TICKS < 2 * NSEG + 2)  begin : g_bad_ticks $error("LINE_TICKS too short for fetch"); end

   logic          run;
   logic          line_end;
   logic          fr_q;
   logic [LW-1:0] cnt;
   logic [LW-1:0] cnt_nxt;
   logic [NSEG-1:0] row;

   assign run = disp_on || !static_on;

   lcd_line_timer #(.LINE_TICKS(LINE_TICKS), .NCOM(NCOM), .NLINE(NLINE)) u_timer (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .run(run),
      .duty_full(duty_full), .cnt(cnt), .cnt_nxt(cnt_nxt),
      .line_end(line_end), .fr(fr_q));

   lcd_row_fetch #(.NSEG(NSEG), .NCOL(NCOL), .NLINE(NLINE), .DW(DW)) u_fetch (
      .clk(clk), .rst_n(rst_n), .run(run), .line_end(line_end),
      .reverse(seg_reverse), .start_line(start_line), .cnt_nxt(cnt_nxt),
      .host_busy(host_busy), .ram_rd(ram_rd), .ram_addr(ram_addr),
      .ram_rdata(ram_rdata), .row(row));

   lcd_com_window #(.NCOM(NCOM), .NLINE(NLINE)) u_com (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .is_slave(is_slave),
      .enable(disp_on), .com_sel(com_sel));

   assign seg_data = !disp_on ? '0 : (static_on ? '1 : row);
   assign fr_out   = is_slave ? fr_in : fr_q;

   AST_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_on |-> (com_sel == '0 && seg_data == '0)); // R7
   AST_STATIC_LIT: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_on && static_on) |-> (&seg_data)); // R8
endmodule

// File: tb/lcd_row_scan_bench.sv
module lcd_row_scan_bench;
   localparam int LT = 128;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        disp_on = 1'b1, static_on = 1'b0, seg_reverse = 1'b0, duty_full = 1'b0;
   logic [4:0]  start_line = '0;
   logic        host_busy = 1'b0;
   int          hmode = 0;

   logic        m_rd, s_rd, m_fr, s_fr;
   logic [8:0]  m_addr, s_addr;
   logic [7:0]  m_rdata = '0, s_rdata = '0;
   logic [15:0] m_com, s_com;
   logic [60:0] m_seg, s_seg;

   logic [7:0]  mem [0:319];
   int cyc = 0, checks = 0, fails = 0;
   int prev_idx = 0, last_t = 0;
   bit first = 1, exp_fr = 0, done = 0;

   lcd_row_scan u_lcd_row_scan (
      .clk(clk), .rst_n(rst_n), .osc_tick(1'b1), .disp_on(disp_on),
      .static_on(static_on), .seg_reverse(seg_reverse), .duty_full(duty_full),
      .is_slave(1'b0), .start_line(start_line), .host_busy(host_busy),
      .ram_rd(m_rd), .ram_addr(m_addr), .ram_rdata(m_rdata), .fr_in(1'b0),
      .fr_out(m_fr), .com_sel(m_com), .seg_data(m_seg));

   lcd_row_scan u_slave (
      .clk(clk), .rst_n(rst_n), .osc_tick(1'b1), .disp_on(disp_on),
      .static_on(static_on), .seg_reverse(seg_reverse), .duty_full(duty_full),
      .is_slave(1'b1), .start_line(start_line), .host_busy(host_busy),
      .ram_rd(s_rd), .ram_addr(s_addr), .ram_rdata(s_rdata), .fr_in(m_fr),
      .fr_out(s_fr), .com_sel(s_com), .seg_data(s_seg));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (m_rd) m_rdata <= mem[int'(m_addr[8:7]) * 80 + int'(m_addr[6:0])];
      if (s_rd) s_rdata <= mem[int'(s_addr[8:7]) * 80 + int'(s_addr[6:0])];
   end

   always @(negedge clk)
      host_busy <= (hmode == 1 && cyc % 3 == 0) || (hmode == 2 && cyc % 5 < 2);

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic [60:0] exp_row(input int n);
      logic [60:0] r;
      int line = (int'(start_line) + n) % 32;
      for (int s = 0; s < 61; s++) begin
         int col = seg_reverse ? 79 - s : s;
         r[s] = mem[(line / 8) * 80 + col][line % 8];
      end
      return r;
   endfunction

   function automatic int cur_idx();
      for (int i = 0; i < 16; i++) if (m_com == 16'(1 << i)) return i;
      for (int i = 0; i < 16; i++) if (s_com == 16'(1 << i)) return 16 + i;
      return -1;
   endfunction

   task automatic do_reset(input bit dfull, input int st, input bit rev, input int hm);
      rst_n = 1'b0; disp_on = 1'b1; static_on = 1'b0;
      duty_full = dfull; start_line = 5'(st); seg_reverse = rev; hmode = hm;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: counter at 0 (master common 0), row latch clear, FR low
      chk(m_com == 16'h1 && s_com == 16'h0, "R11 com", {m_com, s_com}, 32'h10000);
      chk(m_seg == '0, "R11 row", 64'(m_seg), 64'h0);
      chk(m_fr == 1'b0, "R11 fr", 64'(m_fr), 64'h0);
      prev_idx = 0; exp_fr = 0; first = 1;
   endtask

   task automatic run_lines(input int k);
      int got = 0, guard = 0;
      while (got < k && guard < k * LT * 2 + 10) begin
         @(negedge clk);
         guard++;
         if (cur_idx() != prev_idx) begin
            int idx = cur_idx();
            int expn = (prev_idx + 1) % (duty_full ? 32 : 16);
            got++;
            chk(idx == expn, "R3 R4 order", 64'(idx), 64'(expn));
            if (!first) chk(cyc - last_t == LT, "R3 period", 64'(cyc - last_t), 64'(LT));
            first = 0; last_t = cyc;
            if (idx == 0) exp_fr = ~exp_fr;
            chk(m_fr == exp_fr && s_fr == exp_fr, "R5 fr", {m_fr, s_fr}, {exp_fr, exp_fr});
            if (static_on)
               chk(&m_seg && &s_seg, "R8 static", 64'(m_seg), {3'b0, {61{1'b1}}});
            else begin
               // R1 R2 R6 R10: row latched with the new common, despite host collisions
               chk(m_seg == exp_row(idx), "R1 R2 R6 R10 master row", 64'(m_seg), 64'(exp_row(idx)));
               chk(s_seg == exp_row(idx), "R1 R2 R6 R10 slave row", 64'(s_seg), 64'(exp_row(idx)));
            end
            prev_idx = idx;
         end
      end
      if (got < k) chk(1'b0, "R3 no advance", 64'(got), 64'(k));
   endtask

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL R3 watchdog actual=%0d expected<150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      int idx0;
      bit fr0;
      for (int i = 0; i < 320; i++) mem[i] = 8'((i * 29 + (i / 7) * 13 + 3) ^ (i * 5 / 2));

      do_reset(0, 0, 0, 0);   run_lines(40);
      do_reset(1, 5, 1, 1);   run_lines(70);
      do_reset(1, 31, 0, 2);  run_lines(70);
      do_reset(0, 20, 1, 2);  run_lines(20);

      // R8: static drive lights all segments, commons keep moving
      static_on = 1'b1; run_lines(6);
      static_on = 1'b0; run_lines(3);

      // R7: display off blanks outputs
      disp_on = 1'b0;
      for (int j = 0; j < 3; j++) begin
         repeat (LT) @(negedge clk);
         chk(m_com == '0 && s_com == '0, "R7 com blank", {m_com, s_com}, 64'h0);
         chk(m_seg == '0 && s_seg == '0, "R7 seg blank", 64'(m_seg | s_seg), 64'h0);
      end
      disp_on = 1'b1;
      @(negedge clk);
      prev_idx = cur_idx(); exp_fr = m_fr; first = 1;
      run_lines(4);

      // R9: power save freezes the scan
      idx0 = cur_idx(); fr0 = m_fr;
      disp_on = 1'b0; static_on = 1'b1;
      repeat (3 * LT) @(negedge clk);
      chk(m_com == '0 && m_seg == '0, "R9 R7 blank", {m_com, 48'(m_seg)}, 64'h0);
      disp_on = 1'b1; static_on = 1'b0;
      #1;
      chk(cur_idx() == idx0, "R9 common held", 64'(cur_idx()), 64'(idx0));
      chk(m_fr == fr0, "R9 fr held", 64'(m_fr), 64'(fr0));
      prev_idx = idx0; first = 1;
      run_lines(18);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule